// File: doc/BRIEF.md
# Colour Look-up Table Write Port

This block sits on the register bus of a display controller and owns the colour look-up table. A bus write whose offset falls inside the palette window picks a table entry from its word address. The block takes the red, green and blue bytes from the 32-bit data word and stores them in that entry.

Before it stores a value, the block compares the incoming colour with the one already held. If any of the three bytes differs, it raises a redraw request that covers the whole screen. If all three match, the request is left as it was. The consumer of the request clears it with a one-cycle pulse.

Writes to the gamma window are taken from the bus and dropped. Writes to any other offset have no effect. The display pipeline reads the table through a separate registered port, addressed by an 8-bit pixel index.

Top module: `clut_write_port`

## Requirements
- R1: After reset, every entry i (0..255) holds the grey value {i, i, i}, so the read port returns 24'hiiiiii.
- R2: The read port is registered. The value for the index on `pixIdx` appears on `pixRgb` one clock edge later and holds until the next edge. `pixRgb` is {red[23:16], green[15:8], blue[7:0]}.
- R3: A write with `regWrEn` high whose `regAddr` lies in 0x50000..0x503FF updates entry `regAddr[9:2]`. Red comes from `regWdata[31:24]`, green from `regWdata[23:16]` and blue from `regWdata[15:8]`. The new value is stored at the same edge as the write.
- R4: `regWdata[7:0]` never affects the stored colour.
- R5: A palette write that changes at least one colour byte sets `redrawReq` at the same edge. While `redrawReq` is high, the redraw region runs from (0,0) to `redrawXEnd` = H_RES-1 and `redrawYEnd` = V_RES-1 (1279 and 1023 by default).
- R6: A palette write whose three colour bytes equal the stored entry leaves `redrawReq` unchanged.
- R7: `redrawReq` stays high until a cycle with `redrawClr` high and no colour-changing write. If a colour change and `redrawClr` fall in the same cycle, the request stays set.
- R8: Writes to the gamma window 0x60000..0x603FF change no table entry and do not set `redrawReq`.
- R9: Writes outside both windows (for example 0x50400 or 0x30000) change no entry and do not set `redrawReq`.
- R10: Reset clears `redrawReq` and drives `redrawXEnd` and `redrawYEnd` to zero. The two region outputs also return to zero when a clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (20) | Byte offset of the write within the controller |
| regWdata | input | 32 | Write data word |
| redrawClr | input | 1 | One-cycle acknowledge that clears the redraw request |
| pixIdx | input | 8 | Display-side table index |
| pixRgb | output | 24 | Display-side colour, registered |
| redrawReq | output | 1 | Whole-screen redraw request |
| redrawXEnd | output | COORD_W (12) | Last column of the redraw region |
| redrawYEnd | output | COORD_W (12) | Last row of the redraw region |

## Verification
A table write and any redraw request it raises both take effect at the clock edge that samples the write. A colour read appears one edge after its index is presented. The bench therefore drives a write on a falling edge and moves the read index on the next falling edge. It samples both the colour and the request on the falling edge after that, so every expected value is registered by then.

The latency check for R2 also samples one unit after an index change, before the next rising edge, to confirm that the old value is still held. Clear and write pulses are lowered on the falling edge after the rising edge that consumes them, so each pulse acts at exactly one edge.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int IDX_W     = 8;
  localparam int CH_W      = 8;
  localparam int RGB_W     = 3 * CH_W;
  localparam int ENTRIES   = 1 << IDX_W;
  localparam int WORD_LSB  = 2;
  localparam int WIN_LSB   = IDX_W + WORD_LSB;

  typedef struct packed {
    logic             tblWr;
    logic [IDX_W-1:0] idx;
    logic [RGB_W-1:0] rgb;
  } clutCmd_t;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int                ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] PAL_BASE = 20'h50000,
  parameter int                COORD_W  = 12,
  parameter int                H_RES    = 1280,
  parameter int                V_RES    = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  input  logic               redrawClr,
  input  logic [RGB_W-1:0]   storedRgb,
  output clutCmd_t           cmd,
  output logic               redrawReq,
  output logic [COORD_W-1:0] redrawXEnd,
  output logic [COORD_W-1:0] redrawYEnd
);
  localparam logic [COORD_W-1:0] X_LAST = COORD_W'(H_RES - 1);
  localparam logic [COORD_W-1:0] Y_LAST = COORD_W'(V_RES - 1);

  logic palHit;
  logic colourDiffers;
  logic markDirty;

  assign palHit = regAddr[ADDR_W-1:WIN_LSB] == PAL_BASE[ADDR_W-1:WIN_LSB];

  always_comb begin
    cmd.tblWr = regWrEn && palHit;
    cmd.idx   = regAddr[WIN_LSB-1:WORD_LSB];
    cmd.rgb   = {regWdata[31:24], regWdata[23:16], regWdata[15:8]};
  end

  assign colourDiffers = cmd.rgb != storedRgb;
  assign markDirty     = cmd.tblWr && colourDiffers;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redrawReq  <= 1'b0;
      redrawXEnd <= '0;
      redrawYEnd <= '0;
    end else if (markDirty) begin
      redrawReq  <= 1'b1;
      redrawXEnd <= X_LAST;
      redrawYEnd <= Y_LAST;
    end else if (redrawClr) begin
      redrawReq  <= 1'b0;
      redrawXEnd <= '0;
      redrawYEnd <= '0;
    end
  end
endmodule

// File: rtl/clut_datapath.sv
module clut_datapath
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  clutCmd_t         cmd,
  input  logic [IDX_W-1:0] pixIdx,
  output logic [RGB_W-1:0] storedRgb,
  output logic [RGB_W-1:0] pixRgb
);
  logic [RGB_W-1:0] table_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [CH_W-1:0] GREY = CH_W'(e);
    always_ff @(posedge clk) begin
      if (!rstN)
        table_q[e] <= {GREY, GREY, GREY};
      else if (cmd.tblWr && cmd.idx == IDX_W'(e))
        table_q[e] <= cmd.rgb;
    end
  end

  assign storedRgb = table_q[cmd.idx];

  always_ff @(posedge clk) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= table_q[pixIdx];
  end
endmodule

// File: rtl/clut_write_port.sv
module clut_write_port
  import clut_pkg::*;
#(
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] PAL_BASE   = 20'h50000,
  parameter logic [ADDR_W-1:0] GAMMA_BASE = 20'h60000,
  parameter int                COORD_W    = 12,
  parameter int                H_RES      = 1280,
  parameter int                V_RES      = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  input  logic               redrawClr,
  input  logic [IDX_W-1:0]   pixIdx,
  output logic [RGB_W-1:0]   pixRgb,
  output logic               redrawReq,
  output logic [COORD_W-1:0] redrawXEnd,
  output logic [COORD_W-1:0] redrawYEnd
);
  clutCmd_t         cmd;
  logic [RGB_W-1:0] storedRgb;

  clut_ctrl #(
    .ADDR_W(ADDR_W), .PAL_BASE(PAL_BASE), .COORD_W(COORD_W),
    .H_RES(H_RES), .V_RES(V_RES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .redrawClr(redrawClr), .storedRgb(storedRgb),
    .cmd(cmd), .redrawReq(redrawReq), .redrawXEnd(redrawXEnd),
    .redrawYEnd(redrawYEnd)
  );

  clut_datapath dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pixIdx(pixIdx),
    .storedRgb(storedRgb), .pixRgb(pixRgb)
  );
endmodule

// File: rtl/clut_write_port_chk.sv
module clut_write_port_chk
  import clut_pkg::*;
#(
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] GAMMA_BASE = 20'h60000,
  parameter int                COORD_W    = 12,
  parameter int                H_RES      = 1280,
  parameter int                V_RES      = 1024
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regWdata,
  input logic               redrawClr,
  input logic [IDX_W-1:0]   pixIdx,
  input logic [RGB_W-1:0]   pixRgb,
  input logic               redrawReq,
  input logic [COORD_W-1:0] redrawXEnd,
  input logic [COORD_W-1:0] redrawYEnd
);
  logic gammaWr;
  assign gammaWr = regWrEn && regAddr[ADDR_W-1:WIN_LSB] == GAMMA_BASE[ADDR_W-1:WIN_LSB];

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    redrawReq && !redrawClr |=> redrawReq); // R7

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    redrawReq && redrawClr && !regWrEn |=> !redrawReq); // R7

  AST_NO_SPONTANEOUS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !redrawReq && !regWrEn |=> !redrawReq); // R6

  AST_GAMMA_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !redrawReq && gammaWr |=> !redrawReq); // R8

  AST_REGION_FULL: assert property (@(posedge clk) disable iff (!rstN)
    redrawReq |-> redrawXEnd == COORD_W'(H_RES - 1) && redrawYEnd == COORD_W'(V_RES - 1)); // R5

  AST_REGION_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !redrawReq |-> redrawXEnd == '0 && redrawYEnd == '0); // R10

  AST_READ_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    $stable(pixIdx) && !regWrEn && $past(!regWrEn) && $past(rstN) |=> $stable(pixRgb)); // R2
endmodule

bind clut_write_port clut_write_port_chk #(
  .ADDR_W(ADDR_W), .GAMMA_BASE(GAMMA_BASE), .COORD_W(COORD_W),
  .H_RES(H_RES), .V_RES(V_RES)
) chk_i (.*);

// File: tb/clut_write_port_tb_top.sv
`timescale 1ns/1ps
module clut_write_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [19:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        redrawClr = 1'b0;
  logic [7:0]  pixIdx = '0;
  logic [23:0] pixRgb;
  logic        redrawReq;
  logic [11:0] redrawXEnd;
  logic [11:0] redrawYEnd;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clut_write_port dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .redrawClr(redrawClr), .pixIdx(pixIdx),
    .pixRgb(pixRgb), .redrawReq(redrawReq), .redrawXEnd(redrawXEnd),
    .redrawYEnd(redrawYEnd)
  );

  // {clr, addr[19:0], data[31:0], idx[7:0], expRgb[23:0], expReq}
  localparam bit [85:0] VEC [11] = '{
    {1'b0, 20'h50014, 32'h11223344, 8'd5,   24'h112233, 1'b1}, // R3 R5
    {1'b1, 20'h50014, 32'h112233AA, 8'd5,   24'h112233, 1'b0}, // R4 R6
    {1'b0, 20'h503FC, 32'hFFEEDD00, 8'd255, 24'hFFEEDD, 1'b1}, // R3 top entry
    {1'b1, 20'h60010, 32'hDEADBEEF, 8'd4,   24'h040404, 1'b0}, // R8
    {1'b0, 20'h50400, 32'h12345678, 8'd0,   24'h000000, 1'b0}, // R9
    {1'b0, 20'h50008, 32'h02020200, 8'd2,   24'h020202, 1'b0}, // R6 vs reset grey
    {1'b0, 20'h50008, 32'h02020300, 8'd2,   24'h020203, 1'b1}, // R5 blue only
    {1'b1, 20'h50014, 32'h11553300, 8'd5,   24'h115533, 1'b1}, // R5 green only
    {1'b1, 20'h5000C, 32'h03030300, 8'd3,   24'h030303, 1'b0}, // R6
    {1'b0, 20'h603FC, 32'h00000000, 8'd255, 24'hFFEEDD, 1'b0}, // R8 last gamma word
    {1'b1, 20'h30000, 32'hABCDEF00, 8'd128, 24'h808080, 1'b0}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [19:0] a, input logic [31:0] d, input logic clr);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d; redrawClr = clr;
    @(negedge clk);
    regWrEn = 1'b0; redrawClr = 1'b0;
  endtask

  task automatic clearPulse();
    @(negedge clk);
    redrawClr = 1'b1;
    @(negedge clk);
    redrawClr = 1'b0;
  endtask

  task automatic readEntry(input logic [7:0] idx, output logic [23:0] rgb);
    pixIdx = idx;
    @(negedge clk);
    rgb = pixRgb;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      applied++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    logic [23:0] rgb;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state: R10 and R1
    check("R10 req", {31'd0, redrawReq}, 32'd0);
    check("R10 xend", {20'd0, redrawXEnd}, 32'd0);
    check("R10 yend", {20'd0, redrawYEnd}, 32'd0);
    for (int i = 0; i < 256; i += 51) begin
      readEntry(8'(i), rgb);
      check("R1 grey ramp", {8'd0, rgb}, {8'd0, 8'(i), 8'(i), 8'(i)});
    end
    readEntry(8'd255, rgb);
    check("R1 grey 255", {8'd0, rgb}, 32'h00FFFFFF);

    // R2 latency: value appears one edge after the index, not before
    readEntry(8'd10, rgb);
    check("R2 after edge", {8'd0, rgb}, 32'h000A0A0A);
    pixIdx = 8'd20;
    #1;
    check("R2 before edge", {8'd0, pixRgb}, 32'h000A0A0A);
    @(negedge clk);
    check("R2 next edge", {8'd0, pixRgb}, 32'h00141414);

    // Vector table
    for (int v = 0; v < 11; v++) begin
      if (VEC[v][85]) clearPulse();
      regWrite(VEC[v][84:65], VEC[v][64:33], 1'b0);
      readEntry(VEC[v][32:25], rgb);
      check("R3 vector colour", {8'd0, rgb}, {8'd0, VEC[v][24:1]});
      check("R5 vector request", {31'd0, redrawReq}, {31'd0, VEC[v][0]});
    end

    // R7: a change and a clear in the same cycle leave the request set
    clearPulse();
    check("R7 cleared", {31'd0, redrawReq}, 32'd0);
    check("R10 region zero after clear", {20'd0, redrawXEnd}, 32'd0);
    regWrite(20'h50010, 32'h0A0B0C00, 1'b1);
    check("R7 set wins", {31'd0, redrawReq}, 32'd1);
    repeat (4) @(negedge clk);
    check("R7 held", {31'd0, redrawReq}, 32'd1);
    check("R5 xend", {20'd0, redrawXEnd}, 32'd1279);
    check("R5 yend", {20'd0, redrawYEnd}, 32'd1023);
    readEntry(8'd4, rgb);
    check("R3 idx4", {8'd0, rgb}, 32'h000A0B0C);
    // R6 identical rewrite with a clear: request drops, does not re-set
    regWrite(20'h50010, 32'h0A0B0C55, 1'b1);
    check("R6 identical write", {31'd0, redrawReq}, 32'd0);
    readEntry(8'd4, rgb);
    check("R4 low byte ignored", {8'd0, rgb}, 32'h000A0B0C);

    finished = 1'b1;
    report();
  end
endmodule